// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words enter on `wclk` when `wr_en` is high and the buffer has room. They leave on `rclk`. A static input `fwft_mode` selects one of two output styles. In standard style every word is moved to `rd_data` by a read strobe, and the active-low `empty_n` flag reports unread words. In fall-through style the oldest word is placed on `rd_data` without a strobe, and the active-low `out_rdy_n` flag marks it valid.

A retransmit strobe `rtx`, sampled on `rclk`, moves the read pointer back to storage location 0, so the stored stream can be replayed from its first word. The replay is only meaningful while the number of words written since reset does not exceed the depth. A static input `zero_lat` selects between two rewind styles. In normal latency, a setup interval blocks output and is reported on `empty_n` or `out_rdy_n`. In zero latency, word 0 is loaded into the output register on the strobe edge itself.

Three level flags complete the block. Almost-empty and half-full are computed in the read domain, and almost-full is computed in the write domain. Thresholds are parameters. The read controller is a state machine with two states. `RS_RUN` is normal operation. `RS_RT_SETUP` is the rewind interval. A normal-latency strobe takes `RS_RUN` to `RS_RT_SETUP`. Another such strobe inside `RS_RT_SETUP` restarts the interval. After `SETUP_CYC` cycles the interval counter expiring returns the controller to `RS_RUN`.

Top module: `fifo_rt`

## Requirements
- R1: Reset gives `rd_data`=0, `empty_n`=0, `out_rdy_n`=1, `full`=0, `almost_full`=0, `almost_empty`=1 and `half_full`=0.
- R2: A write is stored when `wr_en`=1 and `full`=0. `full` is 1 once DEPTH words are unread. A write attempted while `full`=1 is dropped and never appears on the read side.
- R3: With `fwft_mode`=0, each `rclk` edge with `rd_en`=1 and `empty_n`=1 loads the oldest unread word into `rd_data`, in write order. `rd_data` holds otherwise. `empty_n` is 0 when no unread word remains.
- R4: With `fwft_mode`=1, the oldest word appears on `rd_data` with `out_rdy_n`=0 and no `rd_en`. Each `rd_en` edge advances to the next word. `out_rdy_n` returns to 1 when a read consumes the last word.
- R5: A retransmit sets the read position to location 0, so the words that follow begin with the first word written after reset.
- R6: With `fwft_mode`=0 and `zero_lat`=0, `empty_n` is 0 after the `rtx` edge and after the edge that follows it. It rises after the second edge if data is stored. `rd_data` does not change until a read.
- R7: With `fwft_mode`=1 and `zero_lat`=0, `out_rdy_n` is 1 from the `rtx` edge. Word 0 appears with `out_rdy_n`=0 on the third `rclk` edge after it, with no `rd_en`.
- R8: With `zero_lat`=1, word 0 is in `rd_data` right after the `rtx` edge, with no setup interval. In fall-through style, `out_rdy_n`=0 at that point. The next read yields word 1.
- R9: When `rtx` and `rd_en` are high in the same cycle, the retransmit is taken and the read is ignored, so `rd_data` is unchanged by that edge.
- R10: `almost_empty` is 1 when at most PAE_OFS words are unread. It passes through two registers, so after a rewind it changes on the second `rclk` edge after the `rtx` edge.
- R11: `half_full` is 1 when more than DEPTH/2 words are unread. It follows the read pointer directly, so a rewind updates it on the `rtx` edge itself.
- R12: `almost_full` is 1 when at least DEPTH-PAF_OFS words are unread, as seen in the write domain. After a rewind it changes on the second `wclk` edge after the `rtx` edge.
- R13: A retransmit with nothing written leaves `empty_n`=0 and `rd_data` unchanged. Writes made later are read normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft_mode | input | 1 | Static: 1 selects fall-through output style |
| zero_lat | input | 1 | Static: 1 selects zero-latency retransmit |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write word |
| full | output | 1 | No room for another word |
| almost_full | output | 1 | Write-side level at or above DEPTH-PAF_OFS |
| rd_en | input | 1 | Read strobe |
| rtx | input | 1 | Retransmit strobe, sampled on rclk |
| rd_data | output | DW | Output register |
| empty_n | output | 1 | Active low: 0 when nothing is readable or a rewind is in setup |
| out_rdy_n | output | 1 | Active low: 0 when rd_data holds a valid head word in fall-through style |
| almost_empty | output | 1 | Read-side level at or below PAE_OFS |
| half_full | output | 1 | Read-side level above DEPTH/2 |

## Verification
The retransmit strobe and the read strobe can arrive in the same `rclk` cycle. The bench provokes this by raising both together after two words have already been read. It then judges two things: `rd_data` must still hold the second word right after that edge, and the first read after setup must return word 0. Rewinds are also issued while the buffer is drained, in each output style and latency mode. For each one, the bench compares the cycle in which each flag moves against the count of edges set out in the requirements.

// File: rtl/fifo_rt_pkg.sv
`timescale 1ns/10ps
package fifo_rt_pkg;
    typedef enum logic [0:0] {
        RS_RUN      = 1'b0,
        RS_RT_SETUP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/fifo_rt_sync.sv
`timescale 1ns/10ps
module fifo_rt_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/fifo_rt_mem.sv
`timescale 1ns/10ps
module fifo_rt_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_rt_wside.sv
`timescale 1ns/10ps
module fifo_rt_wside #(
    parameter int AW      = 4,
    parameter int PAF_OFS = 2
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          almost_full
);
    localparam int          DEPTH    = 1 << AW;
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
    localparam logic [AW:0] AF_LVL   = (AW+1)'(DEPTH - PAF_OFS);
    localparam logic [AW:0] ONE      = (AW+1)'(1);

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [AW:0] wptr_q;
    logic [AW:0] wptr_d;
    logic [AW:0] wgray_q;
    logic [AW:0] rbin;
    logic [AW:0] wlevel;

    always_comb begin
        rbin        = g2b(rgray_sync);
        wlevel      = wptr_q - rbin;
        full        = (wlevel >= FULL_LVL);
        almost_full = (wlevel >= AF_LVL);
        we          = wr_en && !full;
        wptr_d      = we ? (wptr_q + ONE) : wptr_q;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            wgray_q <= '0;
        end else begin
            wptr_q  <= wptr_d;
            wgray_q <= wptr_d ^ (wptr_d >> 1);
        end
    end

    assign waddr = wptr_q[AW-1:0];
    assign wgray = wgray_q;

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wptr_q)); // R2
    AST_WLEVEL_IN_RANGE: assert property (@(posedge wclk) disable iff (!rst_n)
        wlevel <= FULL_LVL); // R2
endmodule

// File: rtl/fifo_rt_rside.sv
`timescale 1ns/10ps
module fifo_rt_rside
    import fifo_rt_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int PAE_OFS   = 2,
    parameter int SETUP_CYC = 2
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic          zero_lat,
    input  logic          rd_en,
    input  logic          rtx,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          out_rdy_n,
    output logic          almost_empty,
    output logic          half_full
);
    localparam int            DEPTH    = 1 << AW;
    localparam int            CW       = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [AW:0]   ONE      = (AW+1)'(1);
    localparam logic [AW:0]   AE_LVL   = (AW+1)'(PAE_OFS);
    localparam logic [AW:0]   HF_LVL   = (AW+1)'(DEPTH / 2);

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    rd_state_e     state_q;
    rd_state_e     state_d;
    logic [CW-1:0] cnt_q;
    logic [AW:0]   rptr_q;
    logic [AW:0]   rptr_d;
    logic [AW:0]   rgray_q;
    logic [AW:0]   wbin;
    logic [AW:0]   level;
    logic [AW:0]   rlevel_q;
    logic [DW-1:0] rd_data_q;
    logic [DW-1:0] rd_data_d;
    logic          ov_q;
    logic          ov_d;
    logic          ae_q;
    logic          has_data;
    logic          zero_has;
    logic          rt_norm;
    logic          rt_zero;
    logic          take;
    logic          drop;

    // level and strobe decode
    always_comb begin
        wbin      = g2b(wgray_sync);
        level     = wbin - rptr_q;
        has_data  = (level != '0);
        zero_has  = (wbin != '0);
        rt_norm   = rtx && !zero_lat;
        rt_zero   = rtx && zero_lat;
        take      = (state_q == RS_RUN) && !rtx && has_data &&
                    (fwft_mode ? (!ov_q || rd_en) : rd_en);
        drop      = (state_q == RS_RUN) && !rtx && fwft_mode && ov_q &&
                    rd_en && !has_data;
        mem_raddr = rt_zero ? '0 : rptr_q[AW-1:0];
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_RUN:      if (rt_norm) state_d = RS_RT_SETUP;
            RS_RT_SETUP: if (!rt_norm && (cnt_q == LAST_CNT)) state_d = RS_RUN;
            default:     state_d = RS_RUN;
        endcase
    end

    // state register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rt_norm || (state_q != RS_RT_SETUP)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end
    end

    // outputs: pointer, output register, head-valid
    always_comb begin
        rptr_d    = rptr_q;
        rd_data_d = rd_data_q;
        ov_d      = ov_q;
        if (rt_zero) begin
            if (zero_has) begin
                rptr_d    = ONE;
                rd_data_d = mem_rdata;
                ov_d      = fwft_mode;
            end else begin
                rptr_d = '0;
                ov_d   = 1'b0;
            end
        end else if (rt_norm) begin
            rptr_d = '0;
            ov_d   = 1'b0;
        end else if (take) begin
            rptr_d    = rptr_q + ONE;
            rd_data_d = mem_rdata;
            ov_d      = fwft_mode;
        end else if (drop) begin
            ov_d = 1'b0;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q    <= '0;
            rgray_q   <= '0;
            rd_data_q <= '0;
            ov_q      <= 1'b0;
            rlevel_q  <= '0;
            ae_q      <= 1'b1;
        end else begin
            rptr_q    <= rptr_d;
            rgray_q   <= rptr_d ^ (rptr_d >> 1);
            rd_data_q <= rd_data_d;
            ov_q      <= ov_d;
            rlevel_q  <= level;
            ae_q      <= (rlevel_q <= AE_LVL);
        end
    end

    assign rgray        = rgray_q;
    assign rd_data      = rd_data_q;
    assign empty_n      = (state_q == RS_RUN) && has_data;
    assign out_rdy_n    = !ov_q;
    assign almost_empty = ae_q;
    assign half_full    = (level > HF_LVL);

    AST_STD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft_mode && !rd_en && !rtx) |=> $stable(rd_data_q)); // R3
    AST_FWFT_HEAD_HELD: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_mode && ov_q && !rd_en && !rtx) |=> (ov_q && $stable(rd_data_q))); // R4
    AST_RT_REWINDS: assert property (@(posedge rclk) disable iff (!rst_n)
        rt_norm |=> (rptr_q == '0)); // R5
    AST_SETUP_LEN: assert property (@(posedge rclk) disable iff (!rst_n)
        (state_q == RS_RT_SETUP) |-> (cnt_q <= LAST_CNT)); // R6
    AST_ZERO_LAT_LOAD: assert property (@(posedge rclk) disable iff (!rst_n)
        (rt_zero && zero_has) |=> ((rptr_q == ONE) && (ov_q == fwft_mode))); // R8
    AST_RT_BEATS_READ: assert property (@(posedge rclk) disable iff (!rst_n)
        (rt_norm && rd_en) |=> $stable(rd_data_q)); // R9
endmodule

// File: rtl/fifo_rt.sv
`timescale 1ns/10ps
module fifo_rt #(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int PAE_OFS   = 2,
    parameter int PAF_OFS   = 2,
    parameter int SETUP_CYC = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic          zero_lat,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          almost_full,
    input  logic          rd_en,
    input  logic          rtx,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          out_rdy_n,
    output logic          almost_empty,
    output logic          half_full
);
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          we;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_rs;
    logic [AW:0]   rgray_ws;
    logic [DW-1:0] mem_rdata;

    fifo_rt_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    fifo_rt_sync #(.W(AW+1)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    fifo_rt_sync #(.W(AW+1)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    fifo_rt_wside #(.AW(AW), .PAF_OFS(PAF_OFS)) u_wside (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rgray_sync  (rgray_ws),
        .waddr       (waddr),
        .we          (we),
        .wgray       (wgray),
        .full        (full),
        .almost_full (almost_full)
    );

    fifo_rt_rside #(.DW(DW), .AW(AW), .PAE_OFS(PAE_OFS), .SETUP_CYC(SETUP_CYC)) u_rside (
        .rclk         (rclk),
        .rst_n        (rst_n),
        .fwft_mode    (fwft_mode),
        .zero_lat     (zero_lat),
        .rd_en        (rd_en),
        .rtx          (rtx),
        .wgray_sync   (wgray_rs),
        .mem_rdata    (mem_rdata),
        .mem_raddr    (raddr),
        .rgray        (rgray),
        .rd_data      (rd_data),
        .empty_n      (empty_n),
        .out_rdy_n    (out_rdy_n),
        .almost_empty (almost_empty),
        .half_full    (half_full)
    );
endmodule

// File: tb/fifo_rt_bench.sv
`timescale 1ns/10ps
module fifo_rt_bench;
    localparam int DW = 8;
    localparam int NV = 7;
    // fields: [9:5] words written, [4] half_full, [3] almost_empty,
    //         [2] almost_full, [1] full, [0] empty_n  (DEPTH 16, offsets 2)
    localparam logic [9:0] VEC [NV] = '{
        {5'd0,  5'b01000},
        {5'd2,  5'b01001},
        {5'd3,  5'b00001},
        {5'd8,  5'b00001},
        {5'd9,  5'b10001},
        {5'd14, 5'b10101},
        {5'd16, 5'b10111}
    };

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic          zero_lat = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rtx = 1'b0;
    logic          full;
    logic          almost_full;
    logic [DW-1:0] rd_data;
    logic          empty_n;
    logic          out_rdy_n;
    logic          almost_empty;
    logic          half_full;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 rclk = ~rclk;
    always #3.6 wclk = ~wclk;

    fifo_rt u_fifo_rt (
        .wclk         (wclk),
        .rclk         (rclk),
        .rst_n        (rst_n),
        .fwft_mode    (fwft_mode),
        .zero_lat     (zero_lat),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .full         (full),
        .almost_full  (almost_full),
        .rd_en        (rd_en),
        .rtx          (rtx),
        .rd_data      (rd_data),
        .empty_n      (empty_n),
        .out_rdy_n    (out_rdy_n),
        .almost_empty (almost_empty),
        .half_full    (half_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_reset(input logic fw, input logic zl);
        @(negedge rclk);
        rst_n     = 1'b0;
        fwft_mode = fw;
        zero_lat  = zl;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        rtx       = 1'b0;
        repeat (3) @(negedge rclk);
        rst_n = 1'b1;
        repeat (3) @(negedge rclk);
    endtask

    task automatic wr_words(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en   = 1'b1;
            wr_data = base + DW'(i);
        end
        @(negedge wclk);
        wr_en = 1'b0;
        settle();
    endtask

    task automatic rd_one();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [DW-1:0] exp);
        rd_one();
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic rt_pulse(input logic with_rd);
        @(negedge rclk);
        rtx   = 1'b1;
        rd_en = with_rd;
        @(negedge rclk);
        rtx   = 1'b0;
        rd_en = 1'b0;
    endtask

    initial begin
        #500us;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // reset state
        do_reset(1'b0, 1'b0);
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 empty_n", 32'(empty_n), 0);
        chk("R1 out_rdy_n", 32'(out_rdy_n), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 almost_full", 32'(almost_full), 0);
        chk("R1 almost_empty", 32'(almost_empty), 1);
        chk("R1 half_full", 32'(half_full), 0);

        // table of fill levels against flags
        for (int v = 0; v < NV; v++) begin
            do_reset(1'b0, 1'b0);
            wr_words(int'(VEC[v][9:5]), 8'h40);
            chk("R11 half_full level", 32'(half_full), 32'(VEC[v][4]));
            chk("R10 almost_empty level", 32'(almost_empty), 32'(VEC[v][3]));
            chk("R12 almost_full level", 32'(almost_full), 32'(VEC[v][2]));
            chk("R2 full level", 32'(full), 32'(VEC[v][1]));
            chk("R3 empty_n level", 32'(empty_n), 32'(VEC[v][0]));
        end

        // standard read order, then normal-latency rewind
        do_reset(1'b0, 1'b0);
        wr_words(5, 8'hA0);
        for (int i = 0; i < 5; i++) rd_chk("R3 order", 8'hA0 + DW'(i));
        settle();
        chk("R3 drained", 32'(empty_n), 0);
        rt_pulse(1'b0);
        chk("R6 setup edge0 empty_n", 32'(empty_n), 0);
        chk("R10 edge0 almost_empty", 32'(almost_empty), 1);
        @(negedge rclk);
        chk("R6 setup edge1 empty_n", 32'(empty_n), 0);
        chk("R10 edge1 almost_empty", 32'(almost_empty), 1);
        @(negedge rclk);
        chk("R6 edge2 empty_n", 32'(empty_n), 1);
        chk("R10 edge2 almost_empty", 32'(almost_empty), 0);
        chk("R6 no read yet", 32'(rd_data), 32'h A4);
        for (int i = 0; i < 5; i++) rd_chk("R5 replay", 8'hA0 + DW'(i));

        // retransmit and read in the same cycle
        do_reset(1'b0, 1'b0);
        wr_words(4, 8'hC0);
        rd_chk("R3 first", 8'hC0);
        rd_chk("R3 second", 8'hC1);
        rt_pulse(1'b1);
        chk("R9 read ignored", 32'(rd_data), 32'hC1);
        chk("R9 setup empty_n", 32'(empty_n), 0);
        settle();
        rd_chk("R9 replay starts at 0", 8'hC0);

        // zero latency, standard style
        do_reset(1'b0, 1'b1);
        wr_words(4, 8'hC0);
        for (int i = 0; i < 4; i++) rd_one();
        chk("R3 last", 32'(rd_data), 32'hC3);
        rt_pulse(1'b0);
        chk("R8 word0 on edge", 32'(rd_data), 32'hC0);
        chk("R8 no setup", 32'(empty_n), 1);
        rd_chk("R8 next word", 8'hC1);

        // fall-through style
        do_reset(1'b1, 1'b0);
        wr_words(3, 8'hB0);
        chk("R4 head valid", 32'(out_rdy_n), 0);
        chk("R4 head word", 32'(rd_data), 32'hB0);
        rd_chk("R4 advance1", 8'hB1);
        rd_chk("R4 advance2", 8'hB2);
        rd_one();
        chk("R4 drained", 32'(out_rdy_n), 1);
        rt_pulse(1'b0);
        chk("R7 edge0", 32'(out_rdy_n), 1);
        @(negedge rclk);
        chk("R7 edge1", 32'(out_rdy_n), 1);
        @(negedge rclk);
        chk("R7 edge2", 32'(out_rdy_n), 1);
        @(negedge rclk);
        chk("R7 edge3 ready", 32'(out_rdy_n), 0);
        chk("R7 edge3 word0", 32'(rd_data), 32'hB0);

        // zero latency, fall-through style
        do_reset(1'b1, 1'b1);
        wr_words(2, 8'hD0);
        rd_one();
        rd_one();
        chk("R4 empty again", 32'(out_rdy_n), 1);
        rt_pulse(1'b0);
        chk("R8 fwft ready", 32'(out_rdy_n), 0);
        chk("R8 fwft word0", 32'(rd_data), 32'hD0);

        // overflow write dropped
        do_reset(1'b0, 1'b0);
        wr_words(16, 8'h10);
        wr_words(1, 8'hEE);
        chk("R2 full", 32'(full), 1);
        for (int i = 0; i < 16; i++) rd_chk("R2 stored", 8'h10 + DW'(i));
        settle();
        chk("R2 dropped word absent", 32'(empty_n), 0);

        // retransmit with nothing stored
        do_reset(1'b0, 1'b0);
        rt_pulse(1'b0);
        settle();
        chk("R13 still empty", 32'(empty_n), 0);
        chk("R13 data held", 32'(rd_data), 0);
        wr_words(1, 8'h5A);
        chk("R13 later write visible", 32'(empty_n), 1);
        rd_chk("R13 later write read", 8'h5A);

        // half_full on the rewind edge
        do_reset(1'b0, 1'b0);
        wr_words(10, 8'h20);
        for (int i = 0; i < 10; i++) rd_one();
        settle();
        chk("R11 before rewind", 32'(half_full), 0);
        @(negedge rclk);
        rtx = 1'b1;
        @(posedge rclk);
        #0.1;
        rtx = 1'b0;
        chk("R11 on rewind edge", 32'(half_full), 1);

        // almost_full on the second write edge after rewind
        do_reset(1'b0, 1'b0);
        wr_words(14, 8'h30);
        chk("R12 high at 14", 32'(almost_full), 1);
        for (int i = 0; i < 14; i++) rd_one();
        settle();
        chk("R12 low when drained", 32'(almost_full), 0);
        @(negedge rclk);
        rtx = 1'b1;
        @(posedge rclk);
        #0.1;
        rtx = 1'b0;
        @(posedge wclk);
        #0.2;
        chk("R12 first wclk edge", 32'(almost_full), 0);
        @(posedge wclk);
        #0.2;
        chk("R12 second wclk edge", 32'(almost_full), 1);

        settle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule